// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block runs the command sequences of a 32-bit NOR flash array built from two 16-bit devices wired side by side. A host hands it one request at a time (an opcode, a word address and a write word) and gets back a single-cycle completion with an error flag and a result word. The block does the rest on its own: it writes the command words, polls the status register, puts the array back into read mode and judges the outcome.

Three operations are supported: block erase, single-word program, and an identifier probe that confirms the fitted part is a supported 16-Mbit device. Every command byte is placed in both 16-bit halves of the bus, so both devices act in step. Each status poll re-sends the status command before its read. A program counts as good only if the status is clean and a read-back returns the exact word written. A poll limit parameter stops an operation that never becomes ready.

The flash side is a single-outstanding request/acknowledge bus. The flash model, or a bus bridge, may hold off the acknowledge for any number of cycles.

Top module: `nor_cmd_seq`

## Requirements
- R1: A request is taken only in a cycle where `hostReady` and `hostValid` are both high, and `hostReady` is high only while no operation is in progress. Opcode encoding: 0 = block erase, 1 = program, 2 = identifier probe, 3 = reserved.
- R2: Each command word carries its 8-bit code in bits 7:0 and 23:16 with zeros elsewhere: read-array 0xFF, read-ID 0x90, erase setup 0x20, erase confirm 0xD0, program setup 0x40, status read 0x70.
- R3: Block erase writes erase setup and then erase confirm, both to the request address.
- R4: Program writes program setup to the request address, and the next bus write sends the data word to the same address.
- R5: Every poll is a status-read command write followed by a bus read at the request address. Polling stops on the first read in which both ready bits (mask 0x00800080) are set.
- R6: When POLL_LIMIT status reads in a row have come back not ready, polling stops and the operation ends with the error flag set. The result word is the last status read.
- R7: Once polling or the probe reads are finished, a read-array command is written before completion. It goes to the request address, or to address 0 for a probe.
- R8: An erase fails if any bit of mask 0x00200020 is set in the ready status. Its result word is that status.
- R9: A program fails without a read-back if any bit of mask 0x00100010 is set in the ready status, and its result word is that status. Otherwise the word is read back after read-array, and the operation fails if the read-back differs from the data written. The result word is then the read-back value.
- R10: The probe writes read-ID to address 0, reads the manufacturer code at word 0 and the device code at word 1, then writes read-array to address 0. It succeeds only for manufacturer 0x00890089 with device 0x88F388F3 or 0x88F488F4. The result word is the device code.
- R11: A reserved opcode completes with the error flag set and with no bus cycle.
- R12: Once `busReq` is raised, it stays high, with `busWe`, `busAddr` and `busWdata` unchanged, until the cycle in which `busAck` is seen.
- R13: `doneValid` is a one-cycle pulse. `doneErr` and `doneRdata` are valid in that cycle, and the block is ready again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hostValid | input | 1 | Request present |
| hostReady | output | 1 | Block idle, request will be taken |
| hostOp | input | 2 | Operation code |
| hostAddr | input | AW | Word address of the request |
| hostWdata | input | 32 | Word to program |
| doneValid | output | 1 | Completion pulse |
| doneErr | output | 1 | Operation failed |
| doneRdata | output | 32 | Result word (status, read-back or device code) |
| busReq | output | 1 | Flash bus request |
| busWe | output | 1 | 1 = write, 0 = read |
| busAddr | output | AW | Flash word address |
| busWdata | output | 32 | Flash write word |
| busAck | input | 1 | Flash bus acknowledge, one cycle per request |
| busRdata | input | 32 | Flash read word, valid with busAck |

## Verification
A flash model in the bench stalls the acknowledge for a random number of cycles. It keeps a small word array with program-only-clears-bits behaviour, and it can be made busy for a chosen number of polls or report erase or program failure. Directed cases cover the following:
- busy counts on both sides of the poll limit, which separates a late ready from a timeout;
- status failures, which separate an erase-bit fault from a program-bit fault;
- programming a word that was not erased, which only the read-back comparison catches;
- each accepted and rejected identifier pair, and the reserved opcode.

Random operations with random addresses, data and busy counts then check the command order and target address of every write, the number of status commands, whether a read-back took place, and the result word.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [1:0] {
    OP_ERASE   = 2'd0,
    OP_PROGRAM = 2'd1,
    OP_PROBE   = 2'd2,
    OP_RSVD    = 2'd3
  } hostOp_e;

  localparam logic [7:0] CODE_ARRAY  = 8'hFF;
  localparam logic [7:0] CODE_ID     = 8'h90;
  localparam logic [7:0] CODE_ESETUP = 8'h20;
  localparam logic [7:0] CODE_ECONF  = 8'hD0;
  localparam logic [7:0] CODE_PSETUP = 8'h40;
  localparam logic [7:0] CODE_STATUS = 8'h70;

  localparam logic [31:0] MASK_READY     = 32'h0080_0080;
  localparam logic [31:0] MASK_ERASE_ERR = 32'h0020_0020;
  localparam logic [31:0] MASK_PGM_ERR   = 32'h0010_0010;
  localparam logic [31:0] ID_MFR         = 32'h0089_0089;
  localparam logic [31:0] ID_DEV_TOP     = 32'h88F3_88F3;
  localparam logic [31:0] ID_DEV_BOT     = 32'h88F4_88F4;

  // place one command byte into both 16-bit halves
  function automatic logic [31:0] dupCode(input logic [7:0] code);
    return {8'h00, code, 8'h00, code};
  endfunction

  typedef enum logic [2:0] {
    WS_ARRAY, WS_ID, WS_ESETUP, WS_ECONF, WS_PSETUP, WS_STATUS, WS_DATA
  } wordSel_e;

  typedef enum logic [1:0] {
    AS_TARGET, AS_ZERO, AS_ONE
  } addrSel_e;

  typedef struct packed {
    logic     req;
    logic     we;
    wordSel_e wsel;
    addrSel_e asel;
    logic     load;
    logic     capResult;
    logic     capMfr;
    logic     incPoll;
    logic     setErr;
  } seqStrobe_t;

endpackage

// File: rtl/nor_seq_dp.sv
module nor_seq_dp
  import nor_seq_pkg::*;
#(
  parameter int AW         = 20,
  parameter int POLL_LIMIT = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  seqStrobe_t    strb,
  input  logic [1:0]    hostOp,
  input  logic [AW-1:0] hostAddr,
  input  logic [31:0]   hostWdata,
  input  logic [31:0]   busRdata,
  output logic [AW-1:0] busAddr,
  output logic [31:0]   busWdata,
  output hostOp_e       curOp,
  output logic          errNow,
  output logic [31:0]   resultWord,
  output logic          rdReady,
  output logic          rdStatusBad,
  output logic          rdMatch,
  output logic          idGood,
  output logic          pollLast
);

  localparam int PCW = $clog2(POLL_LIMIT + 1);

  hostOp_e       opReg;
  logic [AW-1:0] addrReg;
  logic [31:0]   dataReg;
  logic [31:0]   mfrReg;
  logic [31:0]   resultReg;
  logic          errReg;
  logic [PCW-1:0] pollCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      opReg     <= OP_ERASE;
      addrReg   <= '0;
      dataReg   <= '0;
      mfrReg    <= '0;
      resultReg <= '0;
      errReg    <= 1'b0;
      pollCnt   <= '0;
    end else if (strb.load) begin
      opReg     <= hostOp_e'(hostOp);
      addrReg   <= hostAddr;
      dataReg   <= hostWdata;
      resultReg <= '0;
      errReg    <= (hostOp_e'(hostOp) == OP_RSVD);
      pollCnt   <= '0;
    end else begin
      if (strb.setErr)    errReg    <= 1'b1;
      if (strb.incPoll)   pollCnt   <= pollCnt + 1'b1;
      if (strb.capResult) resultReg <= busRdata;
      if (strb.capMfr)    mfrReg    <= busRdata;
    end
  end

  // write word and address selection for the flash bus
  always_comb begin
    unique case (strb.wsel)
      WS_ID:     busWdata = dupCode(CODE_ID);
      WS_ESETUP: busWdata = dupCode(CODE_ESETUP);
      WS_ECONF:  busWdata = dupCode(CODE_ECONF);
      WS_PSETUP: busWdata = dupCode(CODE_PSETUP);
      WS_STATUS: busWdata = dupCode(CODE_STATUS);
      WS_DATA:   busWdata = dataReg;
      default:   busWdata = dupCode(CODE_ARRAY);
    endcase
    unique case (strb.asel)
      AS_ZERO: busAddr = '0;
      AS_ONE:  busAddr = AW'(1);
      default: busAddr = addrReg;
    endcase
  end

  assign curOp       = opReg;
  assign errNow      = errReg;
  assign resultWord  = resultReg;
  assign rdReady     = ((busRdata & MASK_READY) == MASK_READY);
  assign rdStatusBad = |(busRdata & ((opReg == OP_ERASE) ? MASK_ERASE_ERR : MASK_PGM_ERR));
  assign rdMatch     = (busRdata == dataReg);
  assign idGood      = (mfrReg == ID_MFR) &&
                       ((busRdata == ID_DEV_TOP) || (busRdata == ID_DEV_BOT));
  assign pollLast    = (pollCnt == PCW'(POLL_LIMIT - 1));

  // R6: the poll counter never reaches the limit itself
  p_poll_bound_r6: assert property (@(posedge clk) disable iff (rst)
    pollCnt < PCW'(POLL_LIMIT));

  // R2: command writes other than the data word repeat the code in both halves
  p_cmd_halves_r2: assert property (@(posedge clk) disable iff (rst)
    (strb.req && strb.we && strb.wsel != WS_DATA) |->
      (busWdata[15:0] == busWdata[31:16] && busWdata[15:8] == 8'h00));

endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import nor_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hostValid,
  input  logic [1:0] hostOp,
  input  logic       busAck,
  input  hostOp_e    curOp,
  input  logic       errNow,
  input  logic       rdReady,
  input  logic       rdStatusBad,
  input  logic       rdMatch,
  input  logic       idGood,
  input  logic       pollLast,
  output seqStrobe_t strb,
  output logic       hostReady,
  output logic       doneValid
);

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_CONFIRM, S_POLL_CMD, S_POLL_RD,
    S_ID_CMD, S_ID_MFR, S_ID_DEV, S_ARRAY, S_BACK, S_DONE
  } seqState_e;

  seqState_e state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    strb.wsel = WS_ARRAY;
    strb.asel = AS_TARGET;
    hostReady = 1'b0;
    doneValid = 1'b0;
    unique case (state)
      S_IDLE: begin
        hostReady = 1'b1;
        if (hostValid) begin
          strb.load = 1'b1;
          unique case (hostOp_e'(hostOp))
            OP_RSVD:  nextState = S_DONE;
            OP_PROBE: nextState = S_ID_CMD;
            default:  nextState = S_SETUP;
          endcase
        end
      end
      S_SETUP: begin
        strb.req  = 1'b1;
        strb.we   = 1'b1;
        strb.wsel = (curOp == OP_ERASE) ? WS_ESETUP : WS_PSETUP;
        if (busAck) nextState = S_CONFIRM;
      end
      S_CONFIRM: begin
        strb.req  = 1'b1;
        strb.we   = 1'b1;
        strb.wsel = (curOp == OP_ERASE) ? WS_ECONF : WS_DATA;
        if (busAck) nextState = S_POLL_CMD;
      end
      S_POLL_CMD: begin
        strb.req  = 1'b1;
        strb.we   = 1'b1;
        strb.wsel = WS_STATUS;
        if (busAck) nextState = S_POLL_RD;
      end
      S_POLL_RD: begin
        strb.req = 1'b1;
        if (busAck) begin
          strb.capResult = 1'b1;
          if (rdReady) begin
            strb.setErr = rdStatusBad;
            nextState   = S_ARRAY;
          end else if (pollLast) begin
            strb.setErr = 1'b1;
            nextState   = S_ARRAY;
          end else begin
            strb.incPoll = 1'b1;
            nextState    = S_POLL_CMD;
          end
        end
      end
      S_ID_CMD: begin
        strb.req  = 1'b1;
        strb.we   = 1'b1;
        strb.wsel = WS_ID;
        strb.asel = AS_ZERO;
        if (busAck) nextState = S_ID_MFR;
      end
      S_ID_MFR: begin
        strb.req  = 1'b1;
        strb.asel = AS_ZERO;
        if (busAck) begin
          strb.capMfr = 1'b1;
          nextState   = S_ID_DEV;
        end
      end
      S_ID_DEV: begin
        strb.req  = 1'b1;
        strb.asel = AS_ONE;
        if (busAck) begin
          strb.capResult = 1'b1;
          strb.setErr    = !idGood;
          nextState      = S_ARRAY;
        end
      end
      S_ARRAY: begin
        strb.req  = 1'b1;
        strb.we   = 1'b1;
        strb.wsel = WS_ARRAY;
        strb.asel = (curOp == OP_PROBE) ? AS_ZERO : AS_TARGET;
        if (busAck)
          nextState = (curOp == OP_PROGRAM && !errNow) ? S_BACK : S_DONE;
      end
      S_BACK: begin
        strb.req = 1'b1;
        if (busAck) begin
          strb.capResult = 1'b1;
          strb.setErr    = !rdMatch;
          nextState      = S_DONE;
        end
      end
      S_DONE: begin
        doneValid = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  // R13: completion lasts one cycle and the block is free right after
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (rst)
    doneValid |=> (!doneValid && hostReady));

  // R1: never idle and on the bus at once
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !(hostReady && strb.req));

  // R6: a not-ready read at the limit leaves the error flag set
  p_timeout_err_r6: assert property (@(posedge clk) disable iff (rst)
    (state == S_POLL_RD && busAck && !rdReady && pollLast) |=> errNow);

  // R11: a reserved opcode goes straight to completion with the error set
  p_rsvd_op_r11: assert property (@(posedge clk) disable iff (rst)
    (hostReady && hostValid && hostOp == 2'd3) |=> (doneValid && errNow));

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int AW         = 20,
  parameter int POLL_LIMIT = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hostValid,
  output logic          hostReady,
  input  logic [1:0]    hostOp,
  input  logic [AW-1:0] hostAddr,
  input  logic [31:0]   hostWdata,
  output logic          doneValid,
  output logic          doneErr,
  output logic [31:0]   doneRdata,
  output logic          busReq,
  output logic          busWe,
  output logic [AW-1:0] busAddr,
  output logic [31:0]   busWdata,
  input  logic          busAck,
  input  logic [31:0]   busRdata
);

  seqStrobe_t strb;
  hostOp_e    curOp;
  logic       errNow, rdReady, rdStatusBad, rdMatch, idGood, pollLast;

  nor_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .hostValid(hostValid), .hostOp(hostOp), .busAck(busAck),
    .curOp(curOp), .errNow(errNow), .rdReady(rdReady),
    .rdStatusBad(rdStatusBad), .rdMatch(rdMatch), .idGood(idGood),
    .pollLast(pollLast), .strb(strb), .hostReady(hostReady),
    .doneValid(doneValid)
  );

  nor_seq_dp #(.AW(AW), .POLL_LIMIT(POLL_LIMIT)) u_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .hostOp(hostOp), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .busRdata(busRdata), .busAddr(busAddr), .busWdata(busWdata),
    .curOp(curOp), .errNow(errNow), .resultWord(doneRdata),
    .rdReady(rdReady), .rdStatusBad(rdStatusBad), .rdMatch(rdMatch),
    .idGood(idGood), .pollLast(pollLast)
  );

  assign busReq  = strb.req;
  assign busWe   = strb.we;
  assign doneErr = errNow;

  // R12: a pending request is held steady until acknowledged
  p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (busReq && !busAck) |=> (busReq && $stable(busWe) &&
                             $stable(busAddr) && $stable(busWdata)));

endmodule

// File: tb/sim_nor_cmd_seq.sv
module sim_nor_cmd_seq;

  localparam int AW   = 20;
  localparam int PLIM = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hostValid = 1'b0;
  logic          hostReady;
  logic [1:0]    hostOp = 2'd0;
  logic [AW-1:0] hostAddr = '0;
  logic [31:0]   hostWdata = '0;
  logic          doneValid, doneErr;
  logic [31:0]   doneRdata;
  logic          busReq, busWe;
  logic [AW-1:0] busAddr;
  logic [31:0]   busWdata;
  logic          busAck = 1'b0;
  logic [31:0]   busRdata = '0;

  always #2.5 clk = ~clk;

  nor_cmd_seq #(.AW(AW), .POLL_LIMIT(PLIM)) u0 (.*);

  int errors = 0;
  int checks = 0;

  // ---------------- flash model ----------------
  logic [31:0]   mem [16];
  int            mode;          // 0 array, 1 id, 2 status
  bit            pendErase, pendPgm, lastErase;
  int            busyLeft, busyCfg;
  bit            injE, injP;
  logic [31:0]   mfrCode, devCode;
  int            stall;
  int            nWr, nRd, nStatCmd;
  logic [AW-1:0] wAddr [64];
  logic [31:0]   wData [64];

  always @(posedge clk) begin
    if (rst) begin
      busAck <= 1'b0;
      stall = 0;
    end else if (busAck) begin
      busAck <= 1'b0;
    end else if (busReq) begin
      if (stall > 0) stall = stall - 1;
      else begin
        stall = $urandom_range(0, 2);
        busAck <= 1'b1;
        if (busWe) begin
          if (nWr < 64) begin wAddr[nWr] = busAddr; wData[nWr] = busWdata; end
          nWr++;
          if (pendPgm) begin
            mem[busAddr[3:0]] = mem[busAddr[3:0]] & busWdata;
            pendPgm = 0; busyLeft = busyCfg; lastErase = 0; mode = 2;
          end else if (pendErase && busWdata == 32'h00D000D0) begin
            for (int i = 0; i < 16; i++) mem[i] = 32'hFFFF_FFFF;
            pendErase = 0; busyLeft = busyCfg; lastErase = 1; mode = 2;
          end else begin
            pendErase = 0;
            case (busWdata)
              32'h00FF00FF: mode = 0;
              32'h00900090: mode = 1;
              32'h00700070: begin mode = 2; nStatCmd++; end
              32'h00200020: begin pendErase = 1; mode = 2; end
              32'h00400040: begin pendPgm = 1; mode = 2; end
              default: ;
            endcase
          end
        end else begin
          nRd++;
          if (mode == 0) busRdata <= mem[busAddr[3:0]];
          else if (mode == 1)
            busRdata <= (busAddr == 0) ? mfrCode : (busAddr == 1) ? devCode : 32'h0;
          else if (busyLeft > 0) begin
            busRdata <= 32'h0; busyLeft = busyLeft - 1;
          end else
            busRdata <= 32'h00800080 |
                        (lastErase ? (injE ? 32'h00200020 : 32'h0)
                                   : (injP ? 32'h00100010 : 32'h0));
        end
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic        gotErr;
  logic [31:0] gotData;

  task automatic runOp(input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [31:0] d);
    nWr = 0; nRd = 0; nStatCmd = 0; pendErase = 0; pendPgm = 0;
    @(negedge clk);
    while (!hostReady) @(negedge clk);
    hostValid = 1'b1; hostOp = op; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostValid = 1'b0;
    while (!doneValid) @(negedge clk);
    gotErr = doneErr; gotData = doneRdata;
    @(negedge clk);
    check(!doneValid && hostReady, "R13 pulse", {30'd0, doneValid, hostReady}, 32'd1);
  endtask

  task automatic doErase(input logic [AW-1:0] a, input int busy, input bit e);
    logic [31:0] expData;
    bit          tmo;
    busyCfg = busy; injE = e; injP = 0;
    runOp(2'd0, a, 32'h0);
    tmo = (busy >= PLIM);
    expData = tmo ? 32'h0 : (32'h00800080 | (e ? 32'h00200020 : 32'h0));
    check(gotErr == (tmo || e), tmo ? "R6 erase err" : "R8 erase err", gotErr, tmo || e);
    check(gotData == expData, "R8 erase status", gotData, expData);
    check(wData[0] == 32'h00200020 && wAddr[0] == a, "R3 setup", wData[0], 32'h00200020);
    check(wData[1] == 32'h00D000D0 && wAddr[1] == a, "R3 confirm", wData[1], 32'h00D000D0);
    check(nStatCmd == (tmo ? PLIM : busy + 1), "R5 poll count", nStatCmd, tmo ? PLIM : busy + 1);
    check(wData[nWr-1] == 32'h00FF00FF && wAddr[nWr-1] == a, "R7 array", wData[nWr-1], 32'h00FF00FF);
  endtask

  task automatic doProgram(input logic [AW-1:0] a, input logic [31:0] d,
                           input int busy, input bit p);
    logic [31:0] stored, expData;
    bit          tmo, expErr;
    int          expRd;
    busyCfg = busy; injP = p; injE = 0;
    stored = mem[a[3:0]] & d;
    tmo = (busy >= PLIM);
    runOp(2'd1, a, d);
    expErr  = tmo || p || (stored != d);
    expData = tmo ? 32'h0 : (p ? 32'h00900090 : stored);
    expRd   = (tmo ? PLIM : busy + 1) + ((tmo || p) ? 0 : 1);
    check(gotErr == expErr, "R9 program err", gotErr, expErr);
    check(gotData == expData, "R9 program result", gotData, expData);
    check(nRd == expRd, "R9 readback count", nRd, expRd);
    check(wData[0] == 32'h00400040 && wAddr[0] == a, "R4 setup", wData[0], 32'h00400040);
    check(wData[1] == d && wAddr[1] == a, "R4 data", wData[1], d);
    check(wData[nWr-1] == 32'h00FF00FF && wAddr[nWr-1] == a, "R7 array", wData[nWr-1], 32'h00FF00FF);
  endtask

  task automatic doProbe(input logic [31:0] m, input logic [31:0] dv);
    bit ok;
    mfrCode = m; devCode = dv;
    runOp(2'd2, 20'hABCDE, 32'h0);
    ok = (m == 32'h00890089) && (dv == 32'h88F388F3 || dv == 32'h88F488F4);
    check(gotErr == !ok, "R10 probe err", gotErr, !ok);
    check(gotData == dv, "R10 probe result", gotData, dv);
    check(nWr == 2 && nRd == 2, "R10 cycle count", nWr * 16 + nRd, 34);
    check(wData[0] == 32'h00900090 && wAddr[0] == 0, "R2 read-ID word", wData[0], 32'h00900090);
    check(wData[1] == 32'h00FF00FF && wAddr[1] == 0, "R7 probe array", wData[1], 32'h00FF00FF);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) mem[i] = 32'hFFFF_FFFF;
    mode = 0; busyCfg = 0; injE = 0; injP = 0;
    mfrCode = 32'h00890089; devCode = 32'h88F388F3;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(hostReady && !busReq && !doneValid, "R1 reset state",
          {29'd0, hostReady, busReq, doneValid}, 32'd4);

    // directed cases
    doErase(20'h00040, 0, 0);
    doErase(20'h00123, 3, 1);                 // R8 erase fault
    doErase(20'h00200, PLIM - 1, 0);          // R5 last poll ready
    doErase(20'h00201, PLIM, 0);              // R6 timeout
    doProgram(20'h00005, 32'h1234_5678, 2, 0);
    doProgram(20'h00005, 32'hFFFF_0000, 0, 0); // R9 readback mismatch
    doProgram(20'h00007, 32'hCAFE_F00D, 1, 1); // R9 status fault
    doProgram(20'h00008, 32'h0F0F_0F0F, PLIM, 0); // R6 timeout on program
    doProbe(32'h00890089, 32'h88F388F3);
    doProbe(32'h00890089, 32'h88F488F4);
    doProbe(32'h00890089, 32'h88F188F1);
    doProbe(32'h00880088, 32'h88F388F3);

    // R11 reserved opcode
    runOp(2'd3, 20'h1, 32'h0);
    check(gotErr == 1'b1, "R11 reserved err", gotErr, 1);
    check(nWr == 0 && nRd == 0, "R11 no bus cycle", nWr + nRd, 0);

    // random mix
    for (int n = 0; n < 40; n++) begin
      int k;
      k = $urandom_range(0, 9);
      if (k < 2) doErase(AW'($urandom), $urandom_range(0, PLIM - 1), ($urandom_range(0, 3) == 0));
      else if (k < 8) doProgram(AW'($urandom), $urandom, $urandom_range(0, PLIM - 1),
                                ($urandom_range(0, 4) == 0));
      else doProbe(($urandom_range(0, 1) != 0) ? 32'h00890089 : 32'h00890088,
                   32'h88F188F1 + 32'h00010001 * $urandom_range(0, 3));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule